// File: doc/BRIEF.md
# Serial Register Port with Shared Readback Pin

This block is the control-side slave of a synthesizer's three-wire configuration bus. A host frames each transaction by raising an enable line. It then clocks 32 serial clock cycles. The first bit chosen by the host selects read or write, the next six give a register address, and the last 24 carry data. All three bus lines are resynchronised into the system clock domain. Bus clock edges are found by oversampling, so the whole block runs on one clock.

Read data leaves on a single output pin, which is shared with a lock-detect status input. A 24-bit sharing register sits inside the port's own address space, and two of its bits choose how the pin is shared. With both bits clear the pin carries serial data only. The automatic setting shows lock detect until a read frame is recognised. The forced setting shows lock detect permanently. A small bank of general configuration registers is exposed on a flat output bus for the rest of the chip.

Top module: `serial_reg_port`

## Requirements
- R1: After reset every general register and the sharing register hold zero, and the pin carries serial data, which is low while no read is in progress, whatever the lock-detect level.
- R2: A frame whose first sampled bit is low is a write. Address bits are sampled MSB first on rising clock edges 2 to 7. Data bits are sampled MSB first on rising edges 8 to 31. The register changes only after the 32nd falling edge, never before it.
- R3: A frame whose first sampled bit is high is a read. The addressed register is shifted out MSB first, changing after rising edges 8 to 31, so each bit is valid at the falling edge that follows.
- R4: Addresses outside the general range (0 to REG_COUNT-1) and other than 0x1A read as zero, and writes to them change nothing.
- R5: A frame in which the enable drops before the 32nd falling edge commits nothing.
- R6: Address 0x1A is the sharing register, readable and writable and zero after reset. Its bit 12 selects automatic sharing and its bit 13 forces lock-detect output.
- R7: With bits 13 and 12 both clear, the pin carries serial data at all times and never shows lock detect.
- R8: With only bit 12 set, the pin follows lock detect during idle time and during write frames. It switches to read data once a read flag is sampled on the first rising edge, and it returns to lock detect when the enable drops.
- R9: With bit 13 set, the pin follows lock detect at all times, and reads return no data on it.
- R10: With both bits set, bit 13 takes priority and the pin follows lock detect.
- R11: The bit counter clears whenever the enable is low, so a frame started after an aborted one is decoded from its own first edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial bus |
| rst | input | 1 | Synchronous active-high reset |
| sen | input | 1 | Frame enable from the host, high during a frame |
| sclk | input | 1 | Serial bus clock from the host |
| sdi | input | 1 | Serial data from the host |
| lock_det | input | 1 | Lock-detect status to share on the pin |
| pin_out | output | 1 | Shared readback / lock-detect pin |
| reg_q | output | REG_COUNT*24 | General configuration registers, register 0 in the low bits |

## Verification
The bench builds the port with REG_COUNT = 3 and two synchroniser stages. With these values, address 2 is the highest general register and address 3 is the first empty address just above it, so both sides of the implemented range get checked. The serial clock runs at six system clocks per half period. This is close to the smallest ratio that the two synchroniser stages, the edge register and the output register allow, so data that is even one cycle late shows up at the host's sampling point. Each of the four sharing settings is run with the lock-detect level held opposite to the expected data.

// File: rtl/sport_pkg.sv
package sport_pkg;

    localparam int ADDR_W     = 6;
    localparam int DATA_W     = 24;
    localparam int FRAME_CLKS = 1 + ADDR_W + DATA_W + 1;
    localparam int CNT_W      = $clog2(FRAME_CLKS + 1);

    localparam logic [ADDR_W-1:0] SHARE_ADDR = 6'h1A;
    localparam int AUTO_BIT  = 12;
    localparam int FORCE_BIT = 13;

    typedef enum logic [1:0] {
        PIN_SDO  = 2'd0,
        PIN_AUTO = 2'd1,
        PIN_LOCK = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic rise;
        logic fall;
        logic sen;
        logic sdi;
    } bus_ev_t;

    typedef struct packed {
        logic              en;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } wr_req_t;

    function automatic pin_mode_e share_mode(input logic [DATA_W-1:0] r);
        if (r[FORCE_BIT])
            return PIN_LOCK;
        else if (r[AUTO_BIT])
            return PIN_AUTO;
        else
            return PIN_SDO;
    endfunction

endpackage

// File: rtl/sport_sync.sv
module sport_sync
    import sport_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sclk,
    input  logic    sen,
    input  logic    sdi,
    output bus_ev_t ev
);

    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] sen_q;
    logic [STAGES-1:0] sdi_q;
    logic              sclk_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_q    <= '0;
            sen_q     <= '0;
            sdi_q     <= '0;
            sclk_prev <= 1'b0;
        end else begin
            sclk_q    <= {sclk_q[STAGES-2:0], sclk};
            sen_q     <= {sen_q[STAGES-2:0], sen};
            sdi_q     <= {sdi_q[STAGES-2:0], sdi};
            sclk_prev <= sclk_q[STAGES-1];
        end
    end

    always_comb begin
        ev.rise = sclk_q[STAGES-1] & ~sclk_prev;
        ev.fall = ~sclk_q[STAGES-1] & sclk_prev;
        ev.sen  = sen_q[STAGES-1];
        ev.sdi  = sdi_q[STAGES-1];
    end

endmodule

// File: rtl/sport_frame.sv
module sport_frame
    import sport_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_ev_t           ev,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output wr_req_t           wr,
    output logic              sdo,
    output logic              rd_active,
    output logic [CNT_W-1:0]  bit_cnt
);

    localparam logic [CNT_W-1:0] E_FLAG  = CNT_W'(1);
    localparam logic [CNT_W-1:0] E_A_LO  = CNT_W'(2);
    localparam logic [CNT_W-1:0] E_A_HI  = CNT_W'(1 + ADDR_W);
    localparam logic [CNT_W-1:0] E_D_LO  = CNT_W'(2 + ADDR_W);
    localparam logic [CNT_W-1:0] E_D_HI  = CNT_W'(1 + ADDR_W + DATA_W);
    localparam logic [CNT_W-1:0] E_LAST  = CNT_W'(FRAME_CLKS);

    logic [CNT_W-1:0]  cnt;
    logic [CNT_W-1:0]  nxt;
    logic              is_rd;
    logic              done;
    logic [ADDR_W-1:0] addr_sh;
    logic [DATA_W-1:0] rd_sh;
    logic [DATA_W-1:0] wr_sh;
    logic              commit;

    assign nxt     = cnt + 1'b1;
    assign rd_addr = {addr_sh[ADDR_W-2:0], ev.sdi};
    assign commit  = ev.sen && ev.fall && (cnt == E_LAST) && !is_rd && !done;

    always_ff @(posedge clk) begin
        if (rst || !ev.sen) begin
            cnt       <= '0;
            is_rd     <= 1'b0;
            rd_active <= 1'b0;
            done      <= 1'b0;
            sdo       <= 1'b0;
            addr_sh   <= '0;
            rd_sh     <= '0;
            wr_sh     <= '0;
        end else begin
            if (ev.rise && cnt != E_LAST) begin
                cnt <= nxt;
                if (nxt == E_FLAG) begin
                    is_rd     <= ev.sdi;
                    rd_active <= ev.sdi;
                end
                if (nxt >= E_A_LO && nxt <= E_A_HI)
                    addr_sh <= rd_addr;
                if (nxt == E_A_HI)
                    rd_sh <= rdata;
                if (nxt >= E_D_LO && nxt <= E_D_HI) begin
                    wr_sh <= {wr_sh[DATA_W-2:0], ev.sdi};
                    if (is_rd) begin
                        sdo   <= rd_sh[DATA_W-1];
                        rd_sh <= {rd_sh[DATA_W-2:0], 1'b0};
                    end
                end
                if (nxt == E_LAST)
                    sdo <= 1'b0;
            end
            if (commit)
                done <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr <= '0;
        end else begin
            wr.en   <= commit;
            wr.addr <= addr_sh;
            wr.data <= wr_sh;
        end
    end

    assign bit_cnt = cnt;

endmodule

// File: rtl/sport_regs.sv
module sport_regs
    import sport_pkg::*;
#(
    parameter int REG_COUNT = 4
) (
    input  logic                        clk,
    input  logic                        rst,
    input  wr_req_t                     wr,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [DATA_W-1:0]           rdata,
    output pin_mode_e                   mode,
    output logic [REG_COUNT*DATA_W-1:0] reg_q
);

    logic [DATA_W-1:0] gen_q [REG_COUNT];
    logic [DATA_W-1:0] share_q;

    for (genvar g = 0; g < REG_COUNT; g++) begin : g_reg
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(g);
        always_ff @(posedge clk) begin
            if (rst)
                gen_q[g] <= '0;
            else if (wr.en && wr.addr == MY_ADDR)
                gen_q[g] <= wr.data;
        end
        assign reg_q[g*DATA_W +: DATA_W] = gen_q[g];
    end

    always_ff @(posedge clk) begin
        if (rst)
            share_q <= '0;
        else if (wr.en && wr.addr == SHARE_ADDR)
            share_q <= wr.data;
    end

    always_comb begin
        rdata = '0;
        if (rd_addr == SHARE_ADDR)
            rdata = share_q;
        for (int i = 0; i < REG_COUNT; i++)
            if (rd_addr == ADDR_W'(i))
                rdata = gen_q[i];
    end

    assign mode = share_mode(share_q);

endmodule

// File: rtl/sport_pinmux.sv
module sport_pinmux
    import sport_pkg::*;
(
    input  pin_mode_e mode,
    input  logic      rd_active,
    input  logic      sdo,
    input  logic      lock_det,
    output logic      pin_out
);

    always_comb begin
        unique case (mode)
            PIN_LOCK: pin_out = lock_det;
            PIN_AUTO: pin_out = rd_active ? sdo : lock_det;
            default:  pin_out = sdo;
        endcase
    end

endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import sport_pkg::*;
#(
    parameter int REG_COUNT   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        sen,
    input  logic                        sclk,
    input  logic                        sdi,
    input  logic                        lock_det,
    output logic                        pin_out,
    output logic [REG_COUNT*DATA_W-1:0] reg_q
);

    bus_ev_t           ev;
    wr_req_t           wr;
    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] rdata;
    logic              sdo_bit;
    logic              rd_active;
    logic [CNT_W-1:0]  bit_cnt;
    pin_mode_e         mode;

    logic              sen_s;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;

    assign sen_s   = ev.sen;
    assign wr_en   = wr.en;
    assign wr_addr = wr.addr;

    sport_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .sclk (sclk),
        .sen  (sen),
        .sdi  (sdi),
        .ev   (ev)
    );

    sport_frame u_frame (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .rdata     (rdata),
        .rd_addr   (rd_addr),
        .wr        (wr),
        .sdo       (sdo_bit),
        .rd_active (rd_active),
        .bit_cnt   (bit_cnt)
    );

    sport_regs #(.REG_COUNT(REG_COUNT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (rd_addr),
        .rdata   (rdata),
        .mode    (mode),
        .reg_q   (reg_q)
    );

    sport_pinmux u_mux (
        .mode      (mode),
        .rd_active (rd_active),
        .sdo       (sdo_bit),
        .lock_det  (lock_det),
        .pin_out   (pin_out)
    );

endmodule

// File: rtl/sport_checker.sv
module sport_checker
    import sport_pkg::*;
#(
    parameter int REG_COUNT = 4
) (
    input logic                        clk,
    input logic                        rst,
    input logic                        sen_s,
    input logic                        wr_en,
    input logic [ADDR_W-1:0]           wr_addr,
    input logic [REG_COUNT*DATA_W-1:0] reg_q,
    input logic                        pin_out,
    input logic                        lock_det,
    input pin_mode_e                   mode,
    input logic                        rd_active,
    input logic                        sdo_bit,
    input logic [CNT_W-1:0]            bit_cnt
);

    localparam logic [ADDR_W-1:0] FIRST_EMPTY = ADDR_W'(REG_COUNT);

    assert_commit_at_end_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> bit_cnt == CNT_W'(FRAME_CLKS));

    assert_empty_write_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr >= FIRST_EMPTY && wr_addr != SHARE_ADDR) |=> $stable(reg_q));

    assert_no_commit_idle_R5: assert property (@(posedge clk) disable iff (rst)
        !sen_s |-> !wr_en);

    assert_sdo_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        !sen_s |=> !sdo_bit);

    assert_auto_idle_R8: assert property (@(posedge clk) disable iff (rst)
        (mode == PIN_AUTO && !rd_active) |-> pin_out == lock_det);

    assert_forced_lock_R9: assert property (@(posedge clk) disable iff (rst)
        mode == PIN_LOCK |-> pin_out == lock_det);

    assert_cnt_clear_R11: assert property (@(posedge clk) disable iff (rst)
        !sen_s |=> bit_cnt == '0);

endmodule

bind serial_reg_port sport_checker #(.REG_COUNT(REG_COUNT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .sen_s     (sen_s),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .reg_q     (reg_q),
    .pin_out   (pin_out),
    .lock_det  (lock_det),
    .mode      (mode),
    .rd_active (rd_active),
    .sdo_bit   (sdo_bit),
    .bit_cnt   (bit_cnt)
);

// File: tb/sim_serial_reg_port.sv
`timescale 1ns/1ps
module sim_serial_reg_port;

    localparam int NREG = 3;
    localparam int DW   = 24;
    localparam int HP   = 6;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sen = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic lock_det = 1'b0;
    logic pin_out;
    logic [NREG*DW-1:0] reg_q;

    int n_chk = 0;
    int n_fail = 0;

    typedef struct {
        logic  val;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    event smp_ev;

    logic [DW-1:0] m_reg [NREG];

    always #10 clk = ~clk;

    serial_reg_port #(.REG_COUNT(NREG), .SYNC_STAGES(2)) u0 (
        .clk      (clk),
        .rst      (rst),
        .sen      (sen),
        .sclk     (sclk),
        .sdi      (sdi),
        .lock_det (lock_det),
        .pin_out  (pin_out),
        .reg_q    (reg_q)
    );

    task automatic check(input string req, input logic [NREG*DW-1:0] act, input logic [NREG*DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // monitor: pops one expected pin level per sample point
    initial begin
        forever begin
            @(smp_ev);
            if (exp_q.size() == 0) begin
                check("scoreboard-empty", 1, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(e.tag, {{(NREG*DW-1){1'b0}}, pin_out}, {{(NREG*DW-1){1'b0}}, e.val});
            end
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One bus frame. nrise < 32 cuts it short. When chk is set, the pin
    // level expected just before each falling edge 8..31 goes to the queue.
    task automatic xfer(input logic rd, input logic [5:0] a, input logic [DW-1:0] d,
                        input int nrise, input logic chk, input logic [DW-1:0] exp,
                        input string tag);
        logic [NREG*DW-1:0] snap;
        snap = reg_q;
        sen = 1'b1;
        sdi = rd;
        wait_clk(HP);
        for (int k = 1; k <= 32; k++) begin
            sclk = 1'b1;
            wait_clk(HP);
            if (chk && k >= 8 && k <= 31) begin
                exp_t e;
                e.val = exp[31-k];
                e.tag = tag;
                exp_q.push_back(e);
                -> smp_ev;
                #1;
            end
            if (!rd && k == 32)
                check("R2 no commit before last falling edge", reg_q, snap);
            sclk = 1'b0;
            if (k + 1 >= 2 && k + 1 <= 7)
                sdi = a[6-k];
            else if (k + 1 >= 8 && k + 1 <= 31)
                sdi = d[30-k];
            else
                sdi = 1'b0;
            wait_clk(HP);
            if (k == nrise)
                break;
        end
        sen = 1'b0;
        sdi = 1'b0;
        wait_clk(2 * HP);
    endtask

    function automatic logic [NREG*DW-1:0] model_q();
        logic [NREG*DW-1:0] q;
        for (int i = 0; i < NREG; i++)
            q[i*DW +: DW] = m_reg[i];
        return q;
    endfunction

    task automatic wr_reg(input logic [5:0] a, input logic [DW-1:0] d);
        xfer(1'b0, a, d, 32, 1'b0, '0, "");
        if (a < 6'(NREG))
            m_reg[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check("watchdog expired", 1, 0);
        finish_up();
    end

    initial begin
        for (int i = 0; i < NREG; i++)
            m_reg[i] = '0;
        lock_det = 1'b1;
        wait_clk(4);
        rst = 1'b0;
        wait_clk(4);

        // R1: reset state, pin is serial data (low) despite lock high
        check("R1 registers zero", reg_q, '0);
        check("R1 pin low after reset", {{(NREG*DW-1){1'b0}}, pin_out}, '0);
        // R6: sharing register reads zero after reset
        xfer(1'b1, 6'h1A, '0, 32, 1'b1, 24'h000000, "R6 reset value of 0x1A");

        // R2: writes to every general register
        wr_reg(6'd0, 24'hA5C396);
        check("R2 write reg0", reg_q, model_q());
        wr_reg(6'd1, 24'h5A3C69);
        wr_reg(6'd2, 24'hFFFFFF);
        check("R2 write reg1 reg2", reg_q, model_q());

        // R3 / R7: readback in serial-data mode with lock high
        xfer(1'b1, 6'd0, '0, 32, 1'b1, 24'hA5C396, "R3 read reg0");
        xfer(1'b1, 6'd1, '0, 32, 1'b1, 24'h5A3C69, "R3 read reg1");
        xfer(1'b1, 6'd2, '0, 32, 1'b1, 24'hFFFFFF, "R3 read reg2");
        check("R7 idle pin low with lock high", {{(NREG*DW-1){1'b0}}, pin_out}, '0);

        // R4: empty addresses
        wr_reg(6'd3, 24'h123456);
        check("R4 write to address 3 ignored", reg_q, model_q());
        wr_reg(6'h3F, 24'h654321);
        check("R4 write to address 0x3F ignored", reg_q, model_q());
        xfer(1'b1, 6'd3, '0, 32, 1'b1, 24'h000000, "R4 read address 3");
        xfer(1'b1, 6'h3F, '0, 32, 1'b1, 24'h000000, "R4 read address 0x3F");

        // R5 / R11: aborted write, then a clean frame right after
        xfer(1'b0, 6'd1, 24'h0F0F0F, 20, 1'b0, '0, "");
        check("R5 aborted write discarded", reg_q, model_q());
        xfer(1'b0, 6'd1, 24'h0F0F0F, 31, 1'b0, '0, "");
        check("R5 write cut at edge 31 discarded", reg_q, model_q());
        wr_reg(6'd1, 24'h13579B);
        check("R11 frame after abort decoded", reg_q, model_q());
        xfer(1'b1, 6'd1, '0, 32, 1'b1, 24'h13579B, "R11 read after abort");

        // R6 / R8: automatic sharing (bit 12)
        wr_reg(6'h1A, 24'h001000);
        wait_clk(2);
        check("R8 idle pin follows lock high", {{(NREG*DW-1){1'b0}}, pin_out}, 1);
        lock_det = 1'b0;
        wait_clk(1);
        check("R8 idle pin follows lock low", {{(NREG*DW-1){1'b0}}, pin_out}, 0);
        lock_det = 1'b1;
        xfer(1'b1, 6'h1A, '0, 32, 1'b1, 24'h001000, "R6 R8 read 0x1A in auto mode");
        wait_clk(1);
        check("R8 pin back to lock after read", {{(NREG*DW-1){1'b0}}, pin_out}, 1);
        xfer(1'b0, 6'd2, 24'h000000, 32, 1'b1, 24'hFFFFFF, "R8 pin shows lock during write");
        m_reg[2] = 24'h000000;
        check("R8 write in auto mode", reg_q, model_q());

        // R9: forced lock detect (bit 13)
        wr_reg(6'h1A, 24'h002000);
        lock_det = 1'b0;
        wait_clk(1);
        check("R9 pin follows lock low", {{(NREG*DW-1){1'b0}}, pin_out}, 0);
        lock_det = 1'b1;
        wait_clk(1);
        check("R9 pin follows lock high", {{(NREG*DW-1){1'b0}}, pin_out}, 1);
        xfer(1'b1, 6'd0, '0, 32, 1'b1, 24'hFFFFFF, "R9 read blocked, lock high");
        lock_det = 1'b0;
        xfer(1'b1, 6'd1, '0, 32, 1'b1, 24'h000000, "R9 read blocked, lock low");

        // R10: both bits set, force wins
        wr_reg(6'h1A, 24'h003000);
        lock_det = 1'b1;
        wait_clk(1);
        check("R10 idle pin follows lock", {{(NREG*DW-1){1'b0}}, pin_out}, 1);
        xfer(1'b1, 6'd0, '0, 32, 1'b1, 24'hFFFFFF, "R10 read shows lock");

        // R7: back to serial-data mode
        wr_reg(6'h1A, 24'h000000);
        wait_clk(1);
        check("R7 idle pin low, lock high", {{(NREG*DW-1){1'b0}}, pin_out}, 0);
        xfer(1'b1, 6'd0, '0, 32, 1'b1, 24'hA5C396, "R7 read data after mode clear");
        xfer(1'b1, 6'h1A, '0, 32, 1'b1, 24'h000000, "R6 0x1A cleared");

        wait_clk(4);
        if (exp_q.size() != 0)
            check("scoreboard leftover", 32'(exp_q.size()), 0);
        finish_up();
    end

endmodule